// File: doc/BRIEF.md
# Masked CAM Compare Engine

This block holds a small content-addressable table of 64-bit entries, each with its own valid flag, and compares all of them at once against a search key. The key and two mask words are loaded 16 bits at a time through one shared write port. Segment 0 carries bits 15:0 and segment 3 carries bits 63:48. The table entries and their valid flags are loaded through the same port.

A compare is never requested explicitly. It starts by itself when the top segment of the key or of either mask is written, or when the control fields are written. The control fields choose the mask applied during the compare: mask 1, mask 2 or none. A set mask bit removes that bit position from the comparison. The result is registered one clock after the triggering write, and `busy` is high during that clock. The result is a per-entry hit vector, the lowest matching index, an internal match signal, and an active-low external flag. The external flag is gated by a cascade-enable input. A control field can also force the internal match signal to its no-match level.

Top module: `mcam_engine`

## Requirements
- R1: After reset: `hit_vec` = 0, `hit_addr` = 0, `busy` = 0, `mtch_int` = 0, `mf_n` = 1. All entries are invalid, and the key, both masks and the control fields are zero.
- R2: A write sampled at clock edge k starts a compare if it is one of the following: a key or mask write (`wr_tgt` 0 = key, 1 = mask 1, 2 = mask 2) with `wr_seg` = 3, or `ctl_we` = 1. Then `busy` is 1 between edge k and edge k+1, and the outputs show the result from edge k+1.
- R3: The following do not start a compare, keep `busy` at 0 and leave `hit_vec` unchanged: key or mask writes to segments 0 to 2, entry writes (`wr_tgt` = 3), and valid-flag writes.
- R4: An entry whose valid flag is 0 never sets its bit in `hit_vec`, even when its data equals the key.
- R5: The mask applied follows `ctl_msel`: 1 selects mask 1, 2 selects mask 2, 0 and 3 apply no mask.
- R6: A bit set in the selected mask excludes that bit position from the comparison.
- R7: `hit_addr` is the lowest index whose `hit_vec` bit is set, or 0 when none is set.
- R8: `mf_n` is 0 only while `mtch_int` is 1 and `ec_n` is 0. Otherwise it is 1.
- R9: When `ctl_mfd` = 3, `mtch_int` is 0 (and `mf_n` is 1) whatever `hit_vec` holds. Other values of `ctl_mfd` let `mtch_int` follow whether `hit_vec` is non-zero.
- R10: Segment s of a write fills bits 16*s+15 down to 16*s of the addressed word. Segment 0 is the least significant and segment 3 the most significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment write strobe |
| wr_tgt | input | 2 | Write target: 0 key, 1 mask 1, 2 mask 2, 3 table entry |
| wr_seg | input | 2 | Segment index of the write |
| wr_addr | input | 4 | Entry index for entry and valid-flag writes |
| wr_data | input | 16 | Segment data |
| vld_we | input | 1 | Valid-flag write strobe for entry `wr_addr` |
| vld_val | input | 1 | Valid-flag value |
| ctl_we | input | 1 | Control write strobe; starts a compare |
| ctl_msel | input | 2 | Mask-select field to store |
| ctl_mfd | input | 2 | Match-reporting field to store (3 disables) |
| ec_n | input | 1 | Active-low enable of the external flag |
| hit_vec | output | 16 | Per-entry match result |
| hit_addr | output | 4 | Lowest matching entry index |
| mtch_int | output | 1 | Internal match signal |
| mf_n | output | 1 | External match flag, active low |
| busy | output | 1 | High during the clock in which a compare runs |

## Verification
Every write is driven on a falling edge and removed on the next falling edge, so it is captured by exactly one rising edge. `busy` is checked on that next falling edge, where it is due after one register. `hit_vec`, `hit_addr` and `mtch_int` are checked one further falling edge later, after the result register. Writes that must not start a compare are checked at the same falling edge as `busy`, where `busy` must read 0 and the previous `hit_vec` must still be present. `mf_n` is combinational from `ec_n` and the stored control field, so after a change of `ec_n` it is sampled a small delay later within the same cycle.

// File: rtl/mcam_pkg.sv
package mcam_pkg;

    localparam int unsigned DEF_DW = 64;
    localparam int unsigned DEF_SW = 16;
    localparam int unsigned DEF_NE = 16;

    typedef enum logic [1:0] {
        TGT_KEY = 2'd0,
        TGT_MK1 = 2'd1,
        TGT_MK2 = 2'd2,
        TGT_ENT = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        MSEL_NONE = 2'd0,
        MSEL_M1   = 2'd1,
        MSEL_M2   = 2'd2,
        MSEL_OFF  = 2'd3
    } msel_e;

    typedef struct packed {
        logic [1:0] mfd;
        msel_e      msel;
    } ctl_t;

    function automatic logic flag_allowed(input logic [1:0] mfd);
        return mfd != 2'b11;
    endfunction

endpackage

// File: rtl/mcam_segreg.sv
module mcam_segreg #(
    parameter int unsigned DW = 64,
    parameter int unsigned SW = 16,
    localparam int unsigned NSEG = DW / SW,
    localparam int unsigned SGW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [SGW-1:0] seg,
    input  logic [SW-1:0]  din,
    output logic [DW-1:0]  q,
    output logic           last_wr
);

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                q[s*SW +: SW] <= '0;
            else if (we && seg == SGW'(s))
                q[s*SW +: SW] <= din;
        end
    end

    assign last_wr = we && (seg == SGW'(NSEG - 1));

endmodule

// File: rtl/mcam_store.sv
module mcam_store #(
    parameter int unsigned NE = 16,
    parameter int unsigned DW = 64,
    parameter int unsigned SW = 16,
    localparam int unsigned NSEG = DW / SW,
    localparam int unsigned SGW = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int unsigned AW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   seg_we,
    input  logic [SGW-1:0]         seg,
    input  logic [AW-1:0]          addr,
    input  logic [SW-1:0]          din,
    input  logic                   vld_we,
    input  logic                   vld_val,
    output logic [NE-1:0][DW-1:0]  ent,
    output logic [NE-1:0]          vld
);

    for (genvar e = 0; e < NE; e++) begin : g_ent
        logic sel;
        assign sel = (addr == AW'(e));

        always_ff @(posedge clk) begin
            if (rst)
                vld[e] <= 1'b0;
            else if (vld_we && sel)
                vld[e] <= vld_val;
        end

        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            always_ff @(posedge clk) begin
                if (rst)
                    ent[e][s*SW +: SW] <= '0;
                else if (seg_we && sel && seg == SGW'(s))
                    ent[e][s*SW +: SW] <= din;
            end
        end
    end

endmodule

// File: rtl/mcam_match.sv
module mcam_match #(
    parameter int unsigned NE = 16,
    parameter int unsigned DW = 64,
    localparam int unsigned AW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic [NE-1:0][DW-1:0] ent,
    input  logic [NE-1:0]         vld,
    input  logic [DW-1:0]         key,
    input  logic [DW-1:0]         msk,
    output logic [NE-1:0]         hit,
    output logic [AW-1:0]         idx
);

    for (genvar e = 0; e < NE; e++) begin : g_cmp
        assign hit[e] = vld[e] && (((ent[e] ^ key) & ~msk) == '0);
    end

    always_comb begin
        idx = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (hit[i])
                idx = AW'(i);
        end
    end

endmodule

// File: rtl/mcam_engine.sv
module mcam_engine
    import mcam_pkg::*;
#(
    parameter int unsigned DW = DEF_DW,
    parameter int unsigned SW = DEF_SW,
    parameter int unsigned NE = DEF_NE,
    localparam int unsigned NSEG = DW / SW,
    localparam int unsigned SGW = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int unsigned AW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [1:0]     wr_tgt,
    input  logic [SGW-1:0] wr_seg,
    input  logic [AW-1:0]  wr_addr,
    input  logic [SW-1:0]  wr_data,
    input  logic           vld_we,
    input  logic           vld_val,
    input  logic           ctl_we,
    input  logic [1:0]     ctl_msel,
    input  logic [1:0]     ctl_mfd,
    input  logic           ec_n,
    output logic [NE-1:0]  hit_vec,
    output logic [AW-1:0]  hit_addr,
    output logic           mtch_int,
    output logic           mf_n,
    output logic           busy
);

    tgt_e tgt;
    assign tgt = tgt_e'(wr_tgt);

    logic key_we, mk1_we, mk2_we, ent_we;
    assign key_we = wr_en && (tgt == TGT_KEY);
    assign mk1_we = wr_en && (tgt == TGT_MK1);
    assign mk2_we = wr_en && (tgt == TGT_MK2);
    assign ent_we = wr_en && (tgt == TGT_ENT);

    logic [DW-1:0] key_q, mk1_q, mk2_q;
    logic          key_last, mk1_last, mk2_last;

    mcam_segreg #(.DW(DW), .SW(SW)) u_key (
        .clk(clk), .rst(rst), .we(key_we), .seg(wr_seg), .din(wr_data),
        .q(key_q), .last_wr(key_last)
    );

    mcam_segreg #(.DW(DW), .SW(SW)) u_mk1 (
        .clk(clk), .rst(rst), .we(mk1_we), .seg(wr_seg), .din(wr_data),
        .q(mk1_q), .last_wr(mk1_last)
    );

    mcam_segreg #(.DW(DW), .SW(SW)) u_mk2 (
        .clk(clk), .rst(rst), .we(mk2_we), .seg(wr_seg), .din(wr_data),
        .q(mk2_q), .last_wr(mk2_last)
    );

    logic [NE-1:0][DW-1:0] ent;
    logic [NE-1:0]         vld;

    mcam_store #(.NE(NE), .DW(DW), .SW(SW)) u_store (
        .clk(clk), .rst(rst), .seg_we(ent_we), .seg(wr_seg), .addr(wr_addr),
        .din(wr_data), .vld_we(vld_we), .vld_val(vld_val),
        .ent(ent), .vld(vld)
    );

    // control fields
    ctl_t ctl_q;
    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '{mfd: 2'b00, msel: MSEL_NONE};
        else if (ctl_we)
            ctl_q <= '{mfd: ctl_mfd, msel: msel_e'(ctl_msel)};
    end

    logic [1:0] mfd_f;
    assign mfd_f = ctl_q.mfd;

    // compare request: one clock of busy, result latched at its end
    logic trig, busy_q;
    assign trig = key_last || mk1_last || mk2_last || ctl_we;

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else
            busy_q <= trig;
    end

    logic [DW-1:0] eff_msk;
    always_comb begin
        unique case (ctl_q.msel)
            MSEL_M1: eff_msk = mk1_q;
            MSEL_M2: eff_msk = mk2_q;
            default: eff_msk = '0;
        endcase
    end

    logic [NE-1:0] hit_c;
    logic [AW-1:0] idx_c;

    mcam_match #(.NE(NE), .DW(DW)) u_match (
        .ent(ent), .vld(vld), .key(key_q), .msk(eff_msk),
        .hit(hit_c), .idx(idx_c)
    );

    logic [NE-1:0] hit_q;
    logic [AW-1:0] idx_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= '0;
            idx_q <= '0;
        end else if (busy_q) begin
            hit_q <= hit_c;
            idx_q <= idx_c;
        end
    end

    assign hit_vec  = hit_q;
    assign hit_addr = idx_q;
    assign busy     = busy_q;
    assign mtch_int = (|hit_q) && flag_allowed(ctl_q.mfd);
    assign mf_n     = !(mtch_int && !ec_n);

endmodule

// File: rtl/mcam_chk.sv
module mcam_chk #(
    parameter int unsigned NE = 16,
    parameter int unsigned AW = 4,
    parameter int unsigned SGW = 2,
    parameter int unsigned LAST_SEG = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [1:0]     wr_tgt,
    input logic [SGW-1:0] wr_seg,
    input logic           ctl_we,
    input logic           ec_n,
    input logic [NE-1:0]  hit_vec,
    input logic [AW-1:0]  hit_addr,
    input logic           mtch_int,
    input logic           mf_n,
    input logic           busy,
    input logic [1:0]     mfd_f
);

    logic start;
    assign start = ctl_we ||
                   (wr_en && wr_tgt != 2'd3 && wr_seg == SGW'(LAST_SEG));

    // R2
    busy_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R3
    no_spurious_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !busy);

    // R3
    result_held_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(hit_vec));

    // R7
    lowest_index_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_vec != '0) |->
            (hit_vec[hit_addr] && ((hit_vec & ~({NE{1'b1}} << hit_addr)) == '0)));

    // R7
    idle_index_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_vec == '0) |-> (hit_addr == '0));

    // R8
    flag_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ec_n |-> mf_n);

    // R9
    flag_disable_chk: assert property (@(posedge clk) disable iff (rst)
        (mfd_f == 2'b11) |-> (!mtch_int && mf_n));

endmodule

bind mcam_engine mcam_chk #(
    .NE(NE), .AW(AW), .SGW(SGW), .LAST_SEG(NSEG - 1)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_seg(wr_seg),
    .ctl_we(ctl_we), .ec_n(ec_n), .hit_vec(hit_vec), .hit_addr(hit_addr),
    .mtch_int(mtch_int), .mf_n(mf_n), .busy(busy), .mfd_f(mfd_f)
);

// File: tb/sim_mcam_engine.sv
module sim_mcam_engine;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, vld_we, vld_val, ctl_we, ec_n;
    logic [1:0]  wr_tgt, wr_seg, ctl_msel, ctl_mfd;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] hit_vec;
    logic [3:0]  hit_addr;
    logic        mtch_int, mf_n, busy;

    int checks = 0;
    int fails  = 0;

    localparam logic [63:0] WA = 64'h1111_2222_3333_4444;
    localparam logic [63:0] WB = 64'h1111_2222_3333_4455;

    always #(CLK_PER/2) clk = ~clk;

    mcam_engine u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_seg(wr_seg),
        .wr_addr(wr_addr), .wr_data(wr_data), .vld_we(vld_we), .vld_val(vld_val),
        .ctl_we(ctl_we), .ctl_msel(ctl_msel), .ctl_mfd(ctl_mfd), .ec_n(ec_n),
        .hit_vec(hit_vec), .hit_addr(hit_addr), .mtch_int(mtch_int),
        .mf_n(mf_n), .busy(busy)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // caller sits at a falling edge; returns one falling edge later
    task automatic put(input logic [1:0] t, input int s, input logic [3:0] a,
                       input logic [15:0] d);
        wr_en = 1'b1; wr_tgt = t; wr_seg = s[1:0]; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // writes all four segments; for key/mask ends with busy due now
    task automatic put_word(input logic [1:0] t, input logic [3:0] a,
                            input logic [63:0] w, input logic [15:0] held);
        for (int s = 0; s < 4; s++) begin
            put(t, s, a, w[s*16 +: 16]);
            if (s < 3 || t == 2'd3) begin
                chk("R3 busy stays low", {63'd0, busy}, 64'd0);
                chk("R3 hit_vec held", {48'd0, hit_vec}, {48'd0, held});
            end
        end
        if (t != 2'd3)
            chk("R2 busy after last segment", {63'd0, busy}, 64'd1);
    endtask

    task automatic ctl_wr(input logic [1:0] ms, input logic [1:0] md);
        ctl_we = 1'b1; ctl_msel = ms; ctl_mfd = md;
        @(negedge clk);
        ctl_we = 1'b0;
        chk("R2 busy after control write", {63'd0, busy}, 64'd1);
        @(negedge clk);
        chk("R2 busy drops", {63'd0, busy}, 64'd0);
    endtask

    task automatic expect_res(input string tag, input logic [15:0] hv,
                              input logic [3:0] ha, input logic mi);
        chk({tag, " hit_vec"}, {48'd0, hit_vec}, {48'd0, hv});
        chk({"R7 ", tag, " hit_addr"}, {60'd0, hit_addr}, {60'd0, ha});
        chk({tag, " mtch_int"}, {63'd0, mtch_int}, {63'd0, mi});
    endtask

    task automatic t_reset;
        chk("R1 hit_vec", {48'd0, hit_vec}, 64'd0);
        chk("R1 hit_addr", {60'd0, hit_addr}, 64'd0);
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 mtch_int", {63'd0, mtch_int}, 64'd0);
        chk("R1 mf_n", {63'd0, mf_n}, 64'd1);
    endtask

    task automatic t_load;
        put_word(2'd3, 4'd2, WA, 16'h0);
        put_word(2'd3, 4'd5, WA, 16'h0);
        put_word(2'd3, 4'd9, WB, 16'h0);
        put_word(2'd3, 4'd12, WA, 16'h0);  // left invalid
        vld_we = 1'b1; vld_val = 1'b1;
        wr_addr = 4'd2; @(negedge clk);
        wr_addr = 4'd5; @(negedge clk);
        wr_addr = 4'd9; @(negedge clk);
        vld_we = 1'b0;
        chk("R3 valid write no busy", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_basic;
        put_word(2'd0, 4'd0, WA, 16'h0);
        @(negedge clk);
        expect_res("R4 basic", 16'h0024, 4'd2, 1'b1);
        chk("R8 flag low with ec_n low", {63'd0, mf_n}, 64'd0);
    endtask

    task automatic t_gate;
        ec_n = 1'b1; #1;
        chk("R8 flag high with ec_n high", {63'd0, mf_n}, 64'd1);
        @(negedge clk);
        ec_n = 1'b0; #1;
        chk("R8 flag low again", {63'd0, mf_n}, 64'd0);
        @(negedge clk);
    endtask

    task automatic t_valid;
        vld_we = 1'b1; vld_val = 1'b0; wr_addr = 4'd2;
        @(negedge clk);
        vld_we = 1'b0;
        chk("R3 invalidate no busy", {63'd0, busy}, 64'd0);
        chk("R3 invalidate hit held", {48'd0, hit_vec}, 64'h0024);
        ctl_wr(2'd0, 2'd0);
        expect_res("R4 after invalidate", 16'h0020, 4'd5, 1'b1);
    endtask

    task automatic t_masks;
        put_word(2'd1, 4'd0, 64'h0000_0000_0000_00FF, 16'h0020);
        @(negedge clk);
        expect_res("R5 mask1 loaded unselected", 16'h0020, 4'd5, 1'b1);
        ctl_wr(2'd1, 2'd0);
        expect_res("R6 mask1 selected", 16'h0220, 4'd5, 1'b1);
        put_word(2'd2, 4'd0, 64'hFF00_0000_0000_0000, 16'h0220);
        @(negedge clk);
        expect_res("R5 mask2 load recompare with mask1", 16'h0220, 4'd5, 1'b1);
        ctl_wr(2'd2, 2'd0);
        expect_res("R5 mask2 selected", 16'h0020, 4'd5, 1'b1);
        ctl_wr(2'd3, 2'd0);
        expect_res("R5 select 3 no mask", 16'h0020, 4'd5, 1'b1);
    endtask

    task automatic t_segorder;
        ctl_wr(2'd2, 2'd0);
        put_word(2'd0, 4'd0, 64'h2211_2222_3333_4444, 16'h0020);
        @(negedge clk);
        expect_res("R10 top byte masked", 16'h0020, 4'd5, 1'b1);
        ctl_wr(2'd0, 2'd0);
        expect_res("R10 top byte compared", 16'h0000, 4'd0, 1'b0);
    endtask

    task automatic t_disable;
        put_word(2'd0, 4'd0, WA, 16'h0000);
        @(negedge clk);
        ctl_wr(2'd1, 2'd3);
        expect_res("R9 disabled", 16'h0220, 4'd5, 1'b0);
        chk("R9 flag high when disabled", {63'd0, mf_n}, 64'd1);
        ctl_wr(2'd1, 2'd1);
        expect_res("R9 re-enabled", 16'h0220, 4'd5, 1'b1);
        chk("R9 flag low when enabled", {63'd0, mf_n}, 64'd0);
    endtask

    task automatic t_nomatch;
        put_word(2'd0, 4'd0, 64'h0, 16'h0220);
        @(negedge clk);
        expect_res("R7 no match", 16'h0000, 4'd0, 1'b0);
        chk("R8 no match flag high", {63'd0, mf_n}, 64'd1);
    endtask

    initial begin
        #(CLK_PER * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_tgt = 2'd0; wr_seg = 2'd0; wr_addr = 4'd0;
        wr_data = 16'h0; vld_we = 1'b0; vld_val = 1'b0; ctl_we = 1'b0;
        ctl_msel = 2'd0; ctl_mfd = 2'd0; ec_n = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_load;
        t_basic;
        t_gate;
        t_valid;
        t_masks;
        t_segorder;
        t_disable;
        t_nomatch;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule